// File: doc/BRIEF.md
# Rotation Buffer Bank Allocator

This block shares rotation buffer memory among up to `N_PLANES` display planes. A plane uses rotation memory when it is turned by 90 or 270 degrees, or when its frames are stored compressed. Each plane supplies one bit saying whether it uses the memory, one bit marking it as the favoured video plane, and the size it needs. Two bank sizes complete the inputs. After a start pulse the block first counts the users, then visits the planes one per clock in index order. It gives each user a usable amount and reports whether every request fits.

The split is greedy. The free pool begins as the bank 0 size. The bank 1 size is added only when two or more planes use the memory. The last user takes whatever remains. Any earlier user takes half of the pool, rounded down. The exception is the favoured video plane: when bank 1 is non-zero, it takes the full bank 0 size. Each grant is subtracted from the pool. The check fails if a request exceeds its grant, and the index of the first such plane is reported.

States and transitions: `ST_IDLE` goes to `ST_COUNT` on `start`. `ST_COUNT` latches the user count and the starting pool, then goes to `ST_ALLOC` when there is at least one user, or to `ST_FINISH` when there are none. `ST_ALLOC` handles one plane per cycle and goes to `ST_FINISH` after the last index. `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `rotmem_alloc`

## Requirements
- R1: After reset `busy` and `done` are 0, `pass` is 1, `fail_idx` is 0 and every grant is 0.
- R2: The starting pool equals `bank0_size`, plus `bank1_size` only when more than one plane has its `need_mask` bit set. With one user that user is granted exactly `bank0_size`.
- R3: Users are visited in ascending plane index. The last user in that order is granted everything left in the pool.
- R4: A user that is not last and not a favoured plane with non-zero bank 1 is granted floor(pool/2).
- R5: A user that is not last, has its `video1_mask` bit set and sees a non-zero `bank1_size` is granted `bank0_size`. When `bank1_size` is 0, that plane falls under R4.
- R6: Each grant is subtracted from the pool before the next user is visited, so the grants add up to the starting pool.
- R7: `pass` is 0 when any user's request exceeds its grant, and `fail_idx` names the lowest such plane. A request equal to its grant passes.
- R8: A plane whose `need_mask` bit is 0 is granted 0, and its request size has no effect on `pass`.
- R9: With no users, `done` rises on the second rising edge after the one that samples `start`, with `pass` = 1 and all grants 0.
- R10: With at least one user, `done` is a one-cycle pulse seen `N_PLANES`+2 edges after the start edge. `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check (acted on in idle only) |
| need_mask | input | N_PLANES | Plane uses rotation memory |
| video1_mask | input | N_PLANES | Plane is the favoured video plane |
| req_size | input | N_PLANES*SIZE_W | Required size per plane, plane i at bits [i*SIZE_W +: SIZE_W] |
| bank0_size | input | SIZE_W | Size of bank 0 |
| bank1_size | input | SIZE_W | Size of bank 1 |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | All requests fit (valid from done until next start) |
| fail_idx | output | IDX_W | Lowest failing plane |
| grant | output | N_PLANES*(SIZE_W+1) | Usable amount per plane, plane i at bits [i*(SIZE_W+1) +: SIZE_W+1] |

## Verification
The assertions assume that all plane and bank inputs stay steady from `start` until `done`. They also assume that at most one plane is marked favoured, and that this plane comes first among the users. Together these keep the pool from going negative. The directed stimulus changes inputs only while the block is idle, and it marks at most one favoured plane, always the lowest-indexed user. The grant-sum check assumes the pool never wraps, which holds under these conditions.

// File: rtl/rotmem_pkg.sv
package rotmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_ALLOC  = 2'd2,
        ST_FINISH = 2'd3
    } rm_state_t;
endpackage

// File: rtl/rotmem_users.sv
module rotmem_users #(
    parameter int N_PLANES = 4,
    localparam int CW = $clog2(N_PLANES + 1)
) (
    input  logic [N_PLANES-1:0] need_mask,
    output logic [CW-1:0]       users
);
    always_comb begin
        users = '0;
        for (int i = 0; i < N_PLANES; i++)
            users = users + CW'(need_mask[i]);
    end
endmodule

// File: rtl/rotmem_share.sv
module rotmem_share #(
    parameter int SIZE_W = 16,
    localparam int GW = SIZE_W + 1
) (
    input  logic [GW-1:0]     pool,
    input  logic [SIZE_W-1:0] bank0_size,
    input  logic              bank1_nz,
    input  logic              favoured,
    input  logic              last_user,
    output logic [GW-1:0]     usable
);
    always_comb begin
        if (last_user)
            usable = pool;
        else if (favoured && bank1_nz)
            usable = GW'(bank0_size);
        else
            usable = pool >> 1;
    end
endmodule

// File: rtl/rotmem_alloc.sv
module rotmem_alloc
    import rotmem_pkg::*;
#(
    parameter int N_PLANES = 4,
    parameter int SIZE_W   = 16,
    localparam int GW    = SIZE_W + 1,
    localparam int CW    = $clog2(N_PLANES + 1),
    localparam int IDX_W = (N_PLANES > 1) ? $clog2(N_PLANES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N_PLANES-1:0]        need_mask,
    input  logic [N_PLANES-1:0]        video1_mask,
    input  logic [N_PLANES*SIZE_W-1:0] req_size,
    input  logic [SIZE_W-1:0]          bank0_size,
    input  logic [SIZE_W-1:0]          bank1_size,
    output logic                       busy,
    output logic                       done,
    output logic                       pass,
    output logic [IDX_W-1:0]           fail_idx,
    output logic [N_PLANES*GW-1:0]     grant
);
    rm_state_t state, state_nx;

    logic [CW-1:0]    users_now;
    logic [CW-1:0]    remain;
    logic [GW-1:0]    pool;
    logic [IDX_W-1:0] idx;
    logic             pass_q;
    logic [IDX_W-1:0] fail_q;
    logic [GW-1:0]    grant_q [N_PLANES];
    logic [GW-1:0]    usable;
    logic [SIZE_W-1:0] req_cur;
    logic             last_idx;

    rotmem_users #(.N_PLANES(N_PLANES)) u_users (
        .need_mask (need_mask),
        .users     (users_now)
    );

    assign req_cur  = req_size[idx*SIZE_W +: SIZE_W];
    assign last_idx = (idx == IDX_W'(N_PLANES - 1));

    rotmem_share #(.SIZE_W(SIZE_W)) u_share (
        .pool       (pool),
        .bank0_size (bank0_size),
        .bank1_nz   (bank1_size != '0),
        .favoured   (video1_mask[idx]),
        .last_user  (remain == CW'(1)),
        .usable     (usable)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_COUNT;
            ST_COUNT:  state_nx = (users_now != '0) ? ST_ALLOC : ST_FINISH;
            ST_ALLOC:  if (last_idx) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            pool   <= '0;
            idx    <= '0;
            pass_q <= 1'b1;
            fail_q <= '0;
            for (int i = 0; i < N_PLANES; i++) grant_q[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_COUNT: begin
                    remain <= users_now;
                    pool   <= GW'(bank0_size) +
                              ((users_now > CW'(1)) ? GW'(bank1_size) : '0);
                    idx    <= '0;
                    pass_q <= 1'b1;
                    fail_q <= '0;
                    for (int i = 0; i < N_PLANES; i++) grant_q[i] <= '0;
                end
                ST_ALLOC: begin
                    if (need_mask[idx]) begin
                        remain       <= remain - CW'(1);
                        pool         <= pool - usable;
                        grant_q[idx] <= usable;
                        if (GW'(req_cur) > usable && pass_q) begin
                            pass_q <= 1'b0;
                            fail_q <= idx;
                        end
                    end
                    if (!last_idx) idx <= idx + IDX_W'(1);
                end
                ST_FINISH: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        pass     = pass_q;
        fail_idx = fail_q;
        for (int i = 0; i < N_PLANES; i++) grant[i*GW +: GW] = grant_q[i];
    end

    // Assertions
    logic [GW+CW-1:0] grant_sum;
    logic [GW+CW-1:0] pool_start;
    always_comb begin
        grant_sum = '0;
        for (int i = 0; i < N_PLANES; i++) grant_sum = grant_sum + (GW+CW)'(grant_q[i]);
        pool_start = (GW+CW)'(bank0_size) +
                     ((users_now > CW'(1)) ? (GW+CW)'(bank1_size) : '0);
    end

    assert_grant_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && users_now != '0) |-> grant_sum == pool_start);

    assert_single_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && users_now == CW'(1)) |-> grant_sum == (GW+CW)'(bank0_size));

    assert_pool_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALLOC) |=> pool <= $past(pool));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_FINISH) |=> busy);

    assert_fail_is_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> need_mask[fail_idx]);

    assert_inputs_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_COUNT) |-> $stable(need_mask) && $stable(bank0_size));

    for (genvar g = 0; g < N_PLANES; g++) begin : g_chk
        assert_nonuser_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !need_mask[g]) |-> grant[g*GW +: GW] == '0);
    end
endmodule

// File: tb/tb_rotmem_alloc.sv
module tb_rotmem_alloc;
    localparam int N  = 4;
    localparam int SW = 16;
    localparam int GW = SW + 1;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [N-1:0] need_mask = '0, video1_mask = '0;
    logic [N*SW-1:0] req_size = '0;
    logic [SW-1:0] bank0_size = '0, bank1_size = '0;
    logic busy, done, pass;
    logic [1:0] fail_idx;
    logic [N*GW-1:0] grant;

    int checks = 0, failures = 0, latency = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    rotmem_alloc #(.N_PLANES(N), .SIZE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .need_mask(need_mask),
        .video1_mask(video1_mask), .req_size(req_size), .bank0_size(bank0_size),
        .bank1_size(bank1_size), .busy(busy), .done(done), .pass(pass),
        .fail_idx(fail_idx), .grant(grant));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint g(input int i);
        return longint'(grant[i*GW +: GW]);
    endfunction

    task automatic setup(input logic [N-1:0] nm, input logic [N-1:0] vm,
                         input int r0, input int r1, input int r2, input int r3,
                         input int b0, input int b1);
        @(negedge clk);
        need_mask = nm; video1_mask = vm;
        req_size = {SW'(r3), SW'(r2), SW'(r1), SW'(r0)};
        bank0_size = SW'(b0); bank1_size = SW'(b1);
    endtask

    task automatic run_job(input bool_dummy = 0);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        latency = 1;
        while (!done && latency < 50) begin
            @(negedge clk);
            latency++;
        end
        if (!done) timed_out = 1;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 1);
        chk("R1 fail_idx", fail_idx, 0);
        chk("R1 grants", grant, 0);
    endtask

    task automatic t_single();
        setup(4'b0100, 4'b0000, 0, 0, 1000, 0, 1000, 500);
        run_job();
        chk("R2 single user grant", g(2), 1000);
        chk("R2 pass", pass, 1);
        chk("R10 latency", latency, N + 2);
    endtask

    task automatic t_favoured();
        setup(4'b0011, 4'b0001, 1000, 600, 0, 0, 1000, 600);
        run_job();
        chk("R5 favoured grant", g(0), 1000);
        chk("R3 last takes rest", g(1), 600);
        chk("R7 equal passes", pass, 1);
    endtask

    task automatic t_halves();
        setup(4'b1011, 4'b0000, 500, 250, 9999, 251, 1001, 0);
        run_job();
        chk("R4 half p0", g(0), 500);
        chk("R4 half p1", g(1), 250);
        chk("R6 last p3", g(3), 251);
        chk("R8 nonuser grant", g(2), 0);
        chk("R8 nonuser no effect", pass, 1);
    endtask

    task automatic t_fav_nobank1();
        setup(4'b0011, 4'b0001, 0, 0, 0, 0, 801, 0);
        run_job();
        chk("R5 favoured bank1 zero", g(0), 400);
        chk("R3 last", g(1), 401);
    endtask

    task automatic t_fail();
        setup(4'b0111, 4'b0000, 80, 41, 50, 0, 100, 60);
        run_job();
        chk("R7 pass", pass, 0);
        chk("R7 fail_idx", fail_idx, 1);
        chk("R6 p1", g(1), 40);
        chk("R6 p2", g(2), 40);
    endtask

    task automatic t_none();
        setup(4'b0000, 4'b0000, 5, 5, 5, 5, 100, 100);
        run_job();
        chk("R9 latency", latency, 2);
        chk("R9 pass", pass, 1);
        chk("R9 grants", grant, 0);
    endtask

    task automatic t_busy_start();
        setup(4'b0001, 4'b0000, 10, 0, 0, 0, 20, 0);
        @(negedge clk);
        start = 1;
        @(negedge clk);
        latency = 1;
        repeat (2) begin @(negedge clk); latency++; end
        start = 0;
        while (!done && latency < 50) begin @(negedge clk); latency++; end
        if (!done) timed_out = 1;
        chk("R10 latency with extra start", latency, N + 2);
        @(negedge clk);
        chk("R10 done one cycle", done, 0);
        chk("R10 start while busy ignored", busy, 0);
        chk("R3 single grant", g(0), 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_single();
        t_favoured();
        t_halves();
        t_fav_nobank1();
        t_fail();
        t_none();
        t_busy_start();
        if (timed_out) chk("R10 done never seen", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        chk("R10 watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule